// File: doc/BRIEF.md
# Nonvolatile Save/Restore Sequencer

This block is the control core that moves data between a fast SRAM array and its shadow nonvolatile array. It only produces control signals. The memory cells, the analog supply comparators and the decoder that recognises the software command sequence all sit outside it. There are three ways to start a save: a one-cycle software request, an external agent pulling the shared busy line low, or a rise on the low-supply flag. There are two ways to start a restore: a software request, or the power-up condition. The power-up condition is latched at reset and whenever the supply-below-reset flag is seen.

The block keeps a flag that records whether the SRAM has been written since the last completed save or restore. Saves started from the busy line or from a power failure are skipped when this flag is clear. A software save always runs. Every save runs an erase phase and then a program phase. Every restore clears the SRAM and then copies the nonvolatile contents back into it. The shared busy line is split into a pull-low output and a sensed input, so several instances can share one wired-AND line. When an external agent pulls the line low, accesses already under way get a grace window. After a save, and after a request that was skipped, SRAM access stays locked until the line is sensed high again.

Top module: `nvsave_ctrl`

## Requirements
- R1: While `rst` is high, `status` is 0, `busy_pull`, `written` and all four phase outputs are low. A restore is pending when reset ends, and it starts on the first clock with `low_volt` low.
- R2: `status` encodes the activity: 0 for idle (this includes lockout and the power-fail pulse), 1 for grace window, 2 for save (erase or program), 3 for restore (clear or copy).
- R3: A save asserts `erase_en` for exactly ERASE_CYC cycles, followed at once by `prog_en` for exactly PROG_CYC cycles. `busy_pull` is held for the whole save. A software save runs whether or not `written` is set.
- R4: A restore asserts `clear_en` for exactly CLEAR_CYC cycles, followed at once by `copy_en` for exactly COPY_CYC cycles. `sw_restore_req` starts one from idle.
- R5: Every accepted write (`wr_en` high) sets `written` on the next clock. A completed save or restore clears it.
- R6: When `busy_in` is low while the block is idle and `low_volt` is low, a grace window of GRACE_CYC cycles follows, then a save, provided `written` is set. If `written` is clear, no save takes place.
- R7: During the grace window, reads pass through. A write that was accepted in the cycle before keeps `wr_en` as long as its request stays high. A write request that starts inside the window is refused.
- R8: After a save completes, and after a busy-line request that was skipped, `rd_en` and `wr_en` stay low until `busy_in` is sensed high.
- R9: While `low_volt` is high, `wr_en` stays low, and both `sw_save_req` and a low `busy_in` start nothing.
- R10: A rise of `low_volt` pulls `busy_pull` for PF_CYC cycles. A save follows only if `written` is set and `busy_in` is low at the end of the pulse. Otherwise the line is released with no save, and `written` keeps its value.
- R11: A high `below_reset` latches a restore, which runs once `low_volt` falls. A dip of `low_volt` without `below_reset` produces no restore.
- R12: At most one of the four phase outputs is high in any cycle, and `rd_en` and `wr_en` are low whenever any phase output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_save_req | input | 1 | One-cycle software save request |
| sw_restore_req | input | 1 | One-cycle software restore request |
| low_volt | input | 1 | Supply below switch level |
| below_reset | input | 1 | Supply below reset level |
| busy_in | input | 1 | Sensed level of the shared busy line (0 = low) |
| acc_rd | input | 1 | Host read request |
| acc_wr | input | 1 | Host write request |
| busy_pull | output | 1 | Pull the shared busy line low |
| rd_en | output | 1 | Read allowed to the SRAM |
| wr_en | output | 1 | Write allowed to the SRAM |
| erase_en | output | 1 | Nonvolatile erase phase |
| prog_en | output | 1 | Nonvolatile program phase |
| clear_en | output | 1 | SRAM clear phase of a restore |
| copy_en | output | 1 | Nonvolatile-to-SRAM copy phase |
| written | output | 1 | SRAM written since last save or restore |
| status | output | 2 | Activity code (see R2) |

## Verification
The bench builds the block with short phase lengths: grace 3, erase 4, program 5, clear 2, copy 3 and power-fail pulse 2 cycles. With these lengths every save, restore and lockout finishes within a few dozen cycles. This lets the bench sweep the busy-line trigger over both states of the written flag, and the power-fail trigger over the written flag crossed with an external driver holding the line high. The bench counts phase cycles and compares each count with the length parameter it expects. It also checks the erase-to-program order and the grace-window access rules cycle by cycle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRACE,
        ST_ERASE,
        ST_PROG,
        ST_LOCK,
        ST_PFP,
        ST_CLEAR,
        ST_COPY
    } nvs_state_e;

    typedef enum logic [1:0] {
        STAT_IDLE    = 2'd0,
        STAT_GRACE   = 2'd1,
        STAT_SAVE    = 2'd2,
        STAT_RESTORE = 2'd3
    } nvs_status_e;

    typedef enum logic [2:0] {
        REQ_NONE,
        REQ_RESTORE_PEND,
        REQ_PFAIL,
        REQ_SW_RESTORE,
        REQ_SW_SAVE,
        REQ_HW_SAVE,
        REQ_HW_SKIP
    } nvs_req_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic nvs_status_e status_of(input nvs_state_e s);
        case (s)
            ST_GRACE:          return STAT_GRACE;
            ST_ERASE, ST_PROG: return STAT_SAVE;
            ST_CLEAR, ST_COPY: return STAT_RESTORE;
            default:           return STAT_IDLE;
        endcase
    endfunction

    // States in which this instance pulls the shared line low
    function automatic logic drives_line(input nvs_state_e s);
        return (s == ST_PFP) || (s == ST_GRACE) || (s == ST_ERASE) || (s == ST_PROG);
    endfunction

endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/nvs_trigger.sv
module nvs_trigger import nvs_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  logic     idle,
    input  logic     sw_save_req,
    input  logic     sw_restore_req,
    input  logic     low_volt,
    input  logic     below_reset,
    input  logic     busy_in,
    input  logic     written,
    output nvs_req_e req
);
    logic lv_q;
    logic pf_arm_q;
    logic restore_pend_q;
    logic pf_now;

    // A supply fall is remembered until served or until the supply recovers
    assign pf_now = pf_arm_q | (low_volt & ~lv_q);

    always_comb begin
        req = REQ_NONE;
        if (idle) begin
            if (restore_pend_q && !low_volt) begin
                req = REQ_RESTORE_PEND;
            end else if (pf_now) begin
                req = REQ_PFAIL;
            end else if (sw_restore_req) begin
                req = REQ_SW_RESTORE;
            end else if (sw_save_req && !low_volt) begin
                req = REQ_SW_SAVE;
            end else if (!busy_in && !low_volt) begin
                req = written ? REQ_HW_SAVE : REQ_HW_SKIP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lv_q           <= 1'b0;
            pf_arm_q       <= 1'b0;
            restore_pend_q <= 1'b1;
        end else begin
            lv_q     <= low_volt;
            pf_arm_q <= low_volt && pf_now && (req != REQ_PFAIL);
            if (below_reset) begin
                restore_pend_q <= 1'b1;
            end else if (req == REQ_RESTORE_PEND) begin
                restore_pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq import nvs_pkg::*; #(
    parameter int unsigned GRACE_CYC = 16,
    parameter int unsigned ERASE_CYC = 1000,
    parameter int unsigned PROG_CYC  = 4000,
    parameter int unsigned CLEAR_CYC = 64,
    parameter int unsigned COPY_CYC  = 256,
    parameter int unsigned PF_CYC    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  nvs_req_e   req,
    input  logic       busy_in,
    input  logic       written,
    output nvs_state_e state,
    output logic       nv_done
);
    localparam int unsigned MAXD = max_u(max_u(max_u(GRACE_CYC, ERASE_CYC), max_u(PROG_CYC, CLEAR_CYC)),
                                         max_u(COPY_CYC, PF_CYC));
    localparam int unsigned CW   = $clog2(MAXD + 1);

    nvs_state_e    state_q;
    nvs_state_e    nxt;
    logic          load;
    logic          done;
    logic [CW-1:0] load_val;

    function automatic logic [CW-1:0] span(input nvs_state_e s);
        case (s)
            ST_GRACE: return CW'(GRACE_CYC - 1);
            ST_ERASE: return CW'(ERASE_CYC - 1);
            ST_PROG:  return CW'(PROG_CYC - 1);
            ST_CLEAR: return CW'(CLEAR_CYC - 1);
            ST_COPY:  return CW'(COPY_CYC - 1);
            ST_PFP:   return CW'(PF_CYC - 1);
            default:  return '0;
        endcase
    endfunction

    always_comb begin
        nxt = state_q;
        case (state_q)
            ST_IDLE: begin
                case (req)
                    REQ_RESTORE_PEND, REQ_SW_RESTORE: nxt = ST_CLEAR;
                    REQ_PFAIL:   nxt = ST_PFP;
                    REQ_SW_SAVE: nxt = ST_ERASE;
                    REQ_HW_SAVE: nxt = ST_GRACE;
                    REQ_HW_SKIP: nxt = ST_LOCK;
                    default:     nxt = ST_IDLE;
                endcase
            end
            ST_GRACE: if (done) nxt = ST_ERASE;
            ST_ERASE: if (done) nxt = ST_PROG;
            ST_PROG:  if (done) nxt = ST_LOCK;
            ST_LOCK:  if (busy_in) nxt = ST_IDLE;
            ST_PFP:   if (done) nxt = (written && !busy_in) ? ST_GRACE : ST_IDLE;
            ST_CLEAR: if (done) nxt = ST_COPY;
            ST_COPY:  if (done) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign load     = (nxt != state_q);
    assign load_val = span(nxt);

    nvs_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= nxt;
    end

    assign state   = state_q;
    assign nv_done = done && ((state_q == ST_PROG) || (state_q == ST_COPY));
endmodule

// File: rtl/nvs_gate.sv
module nvs_gate import nvs_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  nvs_state_e state,
    input  logic       acc_rd,
    input  logic       acc_wr,
    input  logic       low_volt,
    input  logic       busy_in,
    input  logic       clr_written,
    output logic       rd_en,
    output logic       wr_en,
    output logic       written
);
    logic wr_cont_q;
    logic written_q;

    always_comb begin
        rd_en = 1'b0;
        wr_en = 1'b0;
        case (state)
            ST_IDLE: begin
                rd_en = acc_rd;
                wr_en = acc_wr && !low_volt && (busy_in || wr_cont_q);
            end
            ST_GRACE: begin
                rd_en = acc_rd;
                wr_en = acc_wr && !low_volt && wr_cont_q;
            end
            ST_PFP: rd_en = acc_rd;
            default: begin
                rd_en = 1'b0;
                wr_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cont_q <= 1'b0;
            written_q <= 1'b0;
        end else begin
            wr_cont_q <= wr_en;
            written_q <= clr_written ? 1'b0 : (written_q | wr_en);
        end
    end

    assign written = written_q;
endmodule

// File: rtl/nvsave_ctrl.sv
module nvsave_ctrl import nvs_pkg::*; #(
    parameter int unsigned GRACE_CYC = 16,
    parameter int unsigned ERASE_CYC = 1000,
    parameter int unsigned PROG_CYC  = 4000,
    parameter int unsigned CLEAR_CYC = 64,
    parameter int unsigned COPY_CYC  = 256,
    parameter int unsigned PF_CYC    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_save_req,
    input  logic       sw_restore_req,
    input  logic       low_volt,
    input  logic       below_reset,
    input  logic       busy_in,
    input  logic       acc_rd,
    input  logic       acc_wr,
    output logic       busy_pull,
    output logic       rd_en,
    output logic       wr_en,
    output logic       erase_en,
    output logic       prog_en,
    output logic       clear_en,
    output logic       copy_en,
    output logic       written,
    output logic [1:0] status
);
    nvs_state_e state;
    nvs_req_e   req;
    logic       nv_done;

    nvs_trigger u_trig (
        .clk            (clk),
        .rst            (rst),
        .idle           (state == ST_IDLE),
        .sw_save_req    (sw_save_req),
        .sw_restore_req (sw_restore_req),
        .low_volt       (low_volt),
        .below_reset    (below_reset),
        .busy_in        (busy_in),
        .written        (written),
        .req            (req)
    );

    nvs_seq #(
        .GRACE_CYC (GRACE_CYC),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC),
        .CLEAR_CYC (CLEAR_CYC),
        .COPY_CYC  (COPY_CYC),
        .PF_CYC    (PF_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .busy_in (busy_in),
        .written (written),
        .state   (state),
        .nv_done (nv_done)
    );

    nvs_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .acc_rd      (acc_rd),
        .acc_wr      (acc_wr),
        .low_volt    (low_volt),
        .busy_in     (busy_in),
        .clr_written (nv_done),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .written     (written)
    );

    assign busy_pull = drives_line(state);
    assign erase_en  = (state == ST_ERASE);
    assign prog_en   = (state == ST_PROG);
    assign clear_en  = (state == ST_CLEAR);
    assign copy_en   = (state == ST_COPY);
    assign status    = status_of(state);
endmodule

// File: rtl/nvs_checker.sv
module nvs_checker (
    input logic clk,
    input logic rst,
    input logic low_volt,
    input logic busy_pull,
    input logic rd_en,
    input logic wr_en,
    input logic erase_en,
    input logic prog_en,
    input logic clear_en,
    input logic copy_en,
    input logic written
);
    // R12
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({erase_en, prog_en, clear_en, copy_en}));

    // R12
    no_access_in_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_en | prog_en | clear_en | copy_en) |-> !(rd_en | wr_en));

    // R3
    erase_to_prog_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(erase_en) |-> prog_en);

    // R3
    prog_after_erase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_en) |-> $past(erase_en));

    // R3
    line_held_in_save_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_en | prog_en) |-> busy_pull);

    // R4
    copy_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(copy_en) |-> $past(clear_en));

    // R5
    write_marks_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> written);

    // R9
    no_write_low_supply_chk: assert property (@(posedge clk) disable iff (rst)
        low_volt |-> !wr_en);
endmodule

bind nvsave_ctrl nvs_checker u_nvs_checker (
    .clk       (clk),
    .rst       (rst),
    .low_volt  (low_volt),
    .busy_pull (busy_pull),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .erase_en  (erase_en),
    .prog_en   (prog_en),
    .clear_en  (clear_en),
    .copy_en   (copy_en),
    .written   (written)
);

// File: tb/tb_nvsave_ctrl.sv
`timescale 1ns/1ps
module tb_nvsave_ctrl;
    localparam int G = 3;
    localparam int E = 4;
    localparam int P = 5;
    localparam int C = 2;
    localparam int Y = 3;
    localparam int F = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_save_req = 1'b0, sw_restore_req = 1'b0;
    logic low_volt = 1'b0, below_reset = 1'b0;
    logic acc_rd = 1'b0, acc_wr = 1'b0;
    logic ext_low = 1'b0, hold_high = 1'b0;
    logic busy_in;
    logic busy_pull, rd_en, wr_en, erase_en, prog_en, clear_en, copy_en, written;
    logic [1:0] status;

    // wired line: low if anyone pulls, unless a strong driver holds it high
    assign busy_in = hold_high | ~(busy_pull | ext_low);

    always #10 clk = ~clk;

    nvsave_ctrl #(.GRACE_CYC(G), .ERASE_CYC(E), .PROG_CYC(P),
                  .CLEAR_CYC(C), .COPY_CYC(Y), .PF_CYC(F)) dut (
        .clk(clk), .rst(rst), .sw_save_req(sw_save_req), .sw_restore_req(sw_restore_req),
        .low_volt(low_volt), .below_reset(below_reset), .busy_in(busy_in),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .busy_pull(busy_pull), .rd_en(rd_en),
        .wr_en(wr_en), .erase_en(erase_en), .prog_en(prog_en), .clear_en(clear_en),
        .copy_en(copy_en), .written(written), .status(status));

    int checks = 0, errors = 0;
    int n_erase, n_prog, n_clear, n_copy, n_pull, n_overlap, cyc, last_erase, first_prog;
    int n_st [4];
    bit finished = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_erase = 0; n_prog = 0; n_clear = 0; n_copy = 0; n_pull = 0; n_overlap = 0;
        cyc = 0; last_erase = -1; first_prog = -1;
        for (int i = 0; i < 4; i++) n_st[i] = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        cyc++;
        if (erase_en) begin n_erase++; last_erase = cyc; end
        if (prog_en) begin n_prog++; if (first_prog < 0) first_prog = cyc; end
        if (clear_en) n_clear++;
        if (copy_en) n_copy++;
        if (busy_pull) n_pull++;
        if ((erase_en | prog_en | clear_en | copy_en) && (rd_en | wr_en)) n_overlap++;
        n_st[status]++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_write();
        acc_wr = 1'b1; tick(); acc_wr = 1'b0; tick();
    endtask

    task automatic do_sw_save();
        sw_save_req = 1'b1; tick(); sw_save_req = 1'b0; run(E + P + 3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset state
        run(3);
        check("R1 status", status, 0);
        check("R1 busy_pull", busy_pull, 0);
        check("R1 phases", {erase_en, prog_en, clear_en, copy_en}, 0);
        check("R1 written", written, 0);
        // R1/R4 power-up restore
        rst = 1'b0; clear_counts(); run(C + Y + 4);
        check("R1 powerup clear", n_clear, C);
        check("R4 powerup copy", n_copy, Y);
        check("R2 restore status", n_st[3], C + Y);
        check("R1 no pull", n_pull, 0);

        // R5 write marks, read does not
        acc_rd = 1'b1; #1;
        check("R5 read passes", rd_en, 1);
        tick(); acc_rd = 1'b0;
        check("R5 read no mark", written, 0);
        acc_wr = 1'b1; #1;
        check("R5 write passes", wr_en, 1);
        tick(); acc_wr = 1'b0;
        check("R5 write marks", written, 1);

        // R3 software save, dirty then clean
        for (int d = 1; d >= 0; d--) begin
            clear_counts();
            do_sw_save();
            check("R3 erase len", n_erase, E);
            check("R3 prog len", n_prog, P);
            check("R3 order", first_prog, last_erase + 1);
            check("R3 line held", n_pull, E + P);
            check("R2 save status", n_st[2], E + P);
            check("R5 save clears", written, 0);
        end

        // R6/R8 busy-line trigger sweep over written flag
        for (int w = 0; w < 2; w++) begin
            if (w == 1) do_write();
            clear_counts();
            ext_low = 1'b1;
            run(G + E + P + 4);
            check("R6 grace len", n_st[1], w * G);
            check("R6 erase len", n_erase, w * E);
            check("R6 prog len", n_prog, w * P);
            check("R6 own pull", n_pull, w * (G + E + P));
            acc_rd = 1'b1; acc_wr = 1'b1; #1;
            check("R8 read locked", rd_en, 0);
            check("R8 write locked", wr_en, 0);
            acc_wr = 1'b0; ext_low = 1'b0; tick();
            check("R8 unlocked read", rd_en, 1);
            acc_rd = 1'b0;
            check("R5 written after hw", written, 0);
        end

        // R7 grace window access rules
        acc_wr = 1'b1; tick();
        ext_low = 1'b1; #1;
        check("R7 inflight at fall", wr_en, 1);
        tick();
        check("R2 grace status", status, 1);
        check("R7 inflight continues", wr_en, 1);
        acc_rd = 1'b1; #1;
        check("R7 read in grace", rd_en, 1);
        acc_wr = 1'b0; tick();
        acc_wr = 1'b1; #1;
        check("R7 new write refused", wr_en, 0);
        acc_wr = 1'b0; acc_rd = 1'b0;
        run(G + E + P);
        ext_low = 1'b0; run(2);
        check("R7 back idle", status, 0);
        check("R5 cleared after grace save", written, 0);

        // R10 power-fail sweep: written x external hold-high
        for (int w = 0; w < 2; w++) begin
            for (int h = 0; h < 2; h++) begin
                int save;
                if (written) do_sw_save();
                if (w == 1) do_write();
                save = (w == 1 && h == 0) ? 1 : 0;
                hold_high = h[0];
                clear_counts();
                low_volt = 1'b1;
                run(F + G + E + P + 6);
                check("R10 pull count", n_pull, F + save * (G + E + P));
                check("R10 erase", n_erase, save * E);
                check("R10 prog", n_prog, save * P);
                check("R10 written kept", written, (w == 1 && save == 0) ? 1 : 0);
                // R9 while supply low
                acc_wr = 1'b1; #1;
                check("R9 write blocked", wr_en, 0);
                acc_wr = 1'b0;
                hold_high = 1'b0;
                clear_counts();
                sw_save_req = 1'b1; tick(); sw_save_req = 1'b0;
                ext_low = 1'b1; acc_rd = 1'b1; run(4);
                check("R9 sw save ignored", n_erase, 0);
                check("R9 hw ignored", n_st[1], 0);
                check("R9 reads pass", rd_en, 1);
                ext_low = 1'b0; acc_rd = 1'b0;
                clear_counts();
                low_volt = 1'b0; run(6);
                check("R11 dip no restore", n_clear, 0);
            end
        end

        // R11 latched restore on deep dip
        if (written) do_sw_save();
        low_volt = 1'b1; run(F + 3);
        below_reset = 1'b1; tick(); below_reset = 1'b0;
        clear_counts(); run(4);
        check("R11 waits for supply", n_clear, 0);
        clear_counts();
        low_volt = 1'b0; run(C + Y + 3);
        check("R11 restore clear", n_clear, C);
        check("R11 restore copy", n_copy, Y);

        // R4/R5 software restore clears written
        do_write();
        clear_counts();
        sw_restore_req = 1'b1; tick(); sw_restore_req = 1'b0;
        run(C + Y + 2);
        check("R4 sw clear", n_clear, C);
        check("R4 sw copy", n_copy, Y);
        check("R5 restore clears", written, 0);

        // R12 no access during phases with requests held high
        clear_counts();
        acc_rd = 1'b1; acc_wr = 1'b1;
        sw_restore_req = 1'b1; tick(); sw_restore_req = 1'b0;
        run(C + Y + 2);
        sw_save_req = 1'b1; tick(); sw_save_req = 1'b0;
        run(E + P + 3);
        acc_rd = 1'b0; acc_wr = 1'b0;
        check("R12 overlap", n_overlap, 0);
        check("R12 phases ran", n_clear + n_erase, C + E);

        finish_run();
    end
endmodule